// File: doc/BRIEF.md
# Complementary PWM Dead-Band Inserter

This block sits between the duty-cycle comparators of a motor or power-stage PWM unit and the gate-drive pins. For each channel pair it takes one raw comparison signal and drives a high-side and a low-side output. In complementary operation the two outputs are opposite, and at every switching edge the output that turns on is held back by a programmable gap. During the gap both outputs are off, so the two transistors of a half-bridge never conduct together.

Two gap values, A and B, are shared by every pair. Each value has its own clock prescaler. Every pair picks, through two select bits, which value applies when its comparison signal rises and which applies when it falls. A pair can also be switched to a pass-through independent mode that inserts no gap. The configuration is loaded through a small write port, and that port only accepts writes while the module enable is low.

Top module: `cpwm_deadband`

## Requirements
- R1: After reset every pair drives high output 0 and low output 1, every pair is in complementary mode, and both gap values are zero.
- R2: On a rising edge of a pair's comparison input, the low output is 0 from the next clock edge. The high output turns on N*2^k clocks after that first edge, where N and k are the count and prescale code of the value chosen by the pair's active-edge select bit.
- R3: On a falling edge, the high output is 0 from the next clock edge. The low output turns on after the gap of the value chosen by the pair's inactive-edge select bit, measured in the same way.
- R4: Select word (cfg_sel=1): bit 2p chooses the value for the rising edge of pair p and bit 2p+1 chooses it for the falling edge (0 = value A, 1 = value B). Bit 2*NPAIR+p is the mode bit of pair p.
- R5: Timing word (cfg_sel=0): bits [5:0] hold count A, [7:6] its prescale code k, [13:8] count B and [15:14] its code. A code k makes the counter step once every 2^k clocks. The gap length is exact whatever the prescaler phase was before the edge, because the prescalers restart on every gap load and on every accepted write.
- R6: A selected count of zero inserts no gap. The outputs swap at the same clock edge, one clock after the edge on the input.
- R7: The high and low outputs of a pair are never 1 together. Both are 0 for the whole of a nonzero gap.
- R8: An edge that arrives during a running gap reloads the counter with the value for the new edge. The output that turns on afterwards is the one for the new edge direction.
- R9: With its mode bit set, a pair drives high = input and low = inverted input, each one clock after the input, with no gap.
- R10: A configuration write while run_en is 1 is ignored, and the configuration keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Module enable; blocks configuration writes while high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = timing word, 1 = select/mode word |
| cfg_data | input | 2*(DTW+2) | Write data |
| duty_in | input | NPAIR | Raw duty comparison signal per pair |
| out_hi | output | NPAIR | High-side drive per pair |
| out_lo | output | NPAIR | Low-side drive per pair |

## Verification
The bench sweeps count values including 0 and 63 across all four prescale codes, every combination of the two select bits, and varied idle phases before each edge. A design that failed to restart its prescaler would give gaps that are too short by a phase-dependent amount, and a swapped select bit would time an edge with the wrong value. A zero count that still inserted one dead cycle would show up as one extra cycle with both outputs off. Two further tests target a reversal in the middle of a gap, where a design that kept the old direction would turn the high side on. They also cover writes made while running; an unguarded write path would shorten the next gap to zero.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    localparam int PS_CODE_W = 2;
    localparam int PS_CNT_W  = 3;
    typedef logic [PS_CODE_W-1:0] ps_code_t;
    typedef enum logic {CFG_TIMING = 1'b0, CFG_SELECT = 1'b1} cfg_target_e;
endpackage

// File: rtl/cpwm_prescaler.sv
module cpwm_prescaler
    import cpwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  ps_code_t code,
    output logic     tick
);
    logic [PS_CNT_W-1:0] cnt_d, cnt_q;
    logic [PS_CNT_W-1:0] last;

    always_comb begin
        last = (PS_CNT_W'(1) << code) - PS_CNT_W'(1);
        tick = (cnt_q == last);
        if (clr || tick) cnt_d = '0;
        else             cnt_d = cnt_q + PS_CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair #(
    parameter int DTW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           duty,
    input  logic           indep,
    input  logic           sel_rise,
    input  logic           sel_fall,
    input  logic [DTW-1:0] gap_a,
    input  logic [DTW-1:0] gap_b,
    input  logic           tick_a,
    input  logic           tick_b,
    output logic           hi,
    output logic           lo,
    output logic           load
);
    typedef struct packed {
        logic           prev;
        logic [DTW-1:0] cnt;
        logic           use_b;
        logic           to_hi;
        logic           hi;
        logic           lo;
    } pair_st_t;

    pair_st_t st_d, st_q;
    logic rise, fall, pick_b, step;
    logic [DTW-1:0] gap;

    always_comb begin
        st_d   = st_q;
        st_d.prev = duty;
        load   = 1'b0;
        rise   = duty & ~st_q.prev;
        fall   = ~duty & st_q.prev;
        pick_b = rise ? sel_rise : sel_fall;
        gap    = pick_b ? gap_b : gap_a;
        step   = st_q.use_b ? tick_b : tick_a;
        if (indep) begin
            st_d.hi  = duty;
            st_d.lo  = ~duty;
            st_d.cnt = '0;
        end else if (rise || fall) begin
            load       = 1'b1;
            st_d.use_b = pick_b;
            st_d.to_hi = rise;
            st_d.cnt   = gap;
            if (gap == '0) begin
                st_d.hi = rise;
                st_d.lo = ~rise;
            end else begin
                st_d.hi = 1'b0;
                st_d.lo = 1'b0;
            end
        end else if (st_q.cnt != '0 && step) begin
            st_d.cnt = st_q.cnt - DTW'(1);
            if (st_q.cnt == DTW'(1)) begin
                st_d.hi = st_q.to_hi;
                st_d.lo = ~st_q.to_hi;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: 1'b0, cnt: '0, use_b: 1'b0, to_hi: 1'b0, hi: 1'b0, lo: 1'b1};
        else        st_q <= st_d;
    end

    assign hi = st_q.hi;
    assign lo = st_q.lo;
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband
    import cpwm_pkg::*;
#(
    parameter int NPAIR = 4,
    parameter int DTW   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_en,
    input  logic                 cfg_wr,
    input  logic                 cfg_sel,
    input  logic [2*(DTW+2)-1:0] cfg_data,
    input  logic [NPAIR-1:0]     duty_in,
    output logic [NPAIR-1:0]     out_hi,
    output logic [NPAIR-1:0]     out_lo
);
    localparam int TIMW = 2*(DTW+2);
    localparam int SELW = 3*NPAIR;

    typedef struct packed {
        logic [TIMW-1:0] tim;
        logic [SELW-1:0] sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr_ok, pre_clr;
    logic [NPAIR-1:0] load;
    logic [DTW-1:0] gap_val [2];
    ps_code_t       ps_val  [2];
    logic [1:0]     tick;
    logic [NPAIR-1:0] mode;

    always_comb begin
        cfg_d = cfg_q;
        wr_ok = cfg_wr & ~run_en;
        if (wr_ok) begin
            if (cfg_target_e'(cfg_sel) == CFG_SELECT) cfg_d.sel = cfg_data[SELW-1:0];
            else                                      cfg_d.tim = cfg_data;
        end
        pre_clr = wr_ok | (|load);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mode = cfg_q.sel[3*NPAIR-1:2*NPAIR];

    for (genvar v = 0; v < 2; v++) begin : g_val
        assign gap_val[v] = cfg_q.tim[v*(DTW+2) +: DTW];
        assign ps_val[v]  = cfg_q.tim[v*(DTW+2)+DTW +: 2];
        cpwm_prescaler u_pre (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (pre_clr),
            .code (ps_val[v]),
            .tick (tick[v])
        );
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        cpwm_pair #(.DTW(DTW)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .duty    (duty_in[p]),
            .indep   (mode[p]),
            .sel_rise(cfg_q.sel[2*p]),
            .sel_fall(cfg_q.sel[2*p+1]),
            .gap_a   (gap_val[0]),
            .gap_b   (gap_val[1]),
            .tick_a  (tick[0]),
            .tick_b  (tick[1]),
            .hi      (out_hi[p]),
            .lo      (out_lo[p]),
            .load    (load[p])
        );
    end
endmodule

// File: rtl/cpwm_deadband_chk.sv
module cpwm_deadband_chk #(
    parameter int NPAIR = 4,
    parameter int CW    = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             cfg_wr,
    input logic [NPAIR-1:0] duty_in,
    input logic [NPAIR-1:0] out_hi,
    input logic [NPAIR-1:0] out_lo,
    input logic [NPAIR-1:0] mode,
    input logic [CW-1:0]    cfg_bits
);
    // R7
    never_both_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hi & out_lo) == '0);

    // R10
    locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && run_en) |=> $stable(cfg_bits));

    for (genvar p = 0; p < NPAIR; p++) begin : g_chk
        // R2
        rise_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(duty_in[p]) && !mode[p]) |=> !out_lo[p]);
        // R3
        fall_high_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(duty_in[p]) && !mode[p]) |=> !out_hi[p]);
        // R9
        indep_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mode[p] |=> (out_hi[p] == $past(duty_in[p]) && out_lo[p] == !$past(duty_in[p])));
    end
endmodule

bind cpwm_deadband cpwm_deadband_chk #(.NPAIR(NPAIR), .CW(2*(DTW+2)+3*NPAIR)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .cfg_wr  (cfg_wr),
    .duty_in (duty_in),
    .out_hi  (out_hi),
    .out_lo  (out_lo),
    .mode    (mode),
    .cfg_bits(cfg_q)
);

// File: tb/cpwm_deadband_tb.sv
module cpwm_deadband_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int DW = 6;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic cfg_wr = 1'b0;
    logic cfg_sel = 1'b0;
    logic [15:0] cfg_data = '0;
    logic [NP-1:0] duty_in = '0;
    logic [NP-1:0] out_hi, out_lo;

    int checks = 0;
    int errors = 0;
    int both_on = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpwm_deadband #(.NPAIR(NP), .DTW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .duty_in(duty_in),
        .out_hi(out_hi), .out_lo(out_lo)
    );

    always @(negedge clk) if (rst_n && (out_hi & out_lo) != '0) both_on++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [15:0] data);
        cfg_sel = sel; cfg_data = data; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [15:0] tim_word(input int na, input int pa, input int nb, input int pb);
        return {pb[1:0], nb[5:0], pa[1:0], na[5:0]};
    endfunction

    // drive one edge on pair p and measure the both-off gap in clocks
    task automatic measure(input int p, input bit rise, input int exp, input string req);
        int gap = 0;
        int leak = 0;
        duty_in[p] = rise;
        @(negedge clk);
        chk(rise ? !out_lo[p] : !out_hi[p], req, rise ? out_lo[p] : out_hi[p], 0);
        while (!(rise ? out_hi[p] : out_lo[p]) && gap < 2000) begin
            if (rise ? out_lo[p] : out_hi[p]) leak++;
            gap++;
            @(negedge clk);
        end
        chk(gap == exp, req, gap, exp);
        chk(leak == 0 && (rise ? !out_lo[p] : !out_hi[p]), "R7", leak, 0);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", WD_LIMIT, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(out_hi == '0, "R1", out_hi, 0);
        chk(out_lo == '1, "R1", out_lo, 15);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 gaps are zero after reset: immediate swap
        measure(0, 1'b1, 0, "R1");
        measure(0, 1'b0, 0, "R1");

        // R2 R3 R4 R5 R6 sweep
        for (int ia = 0; ia < 5; ia++) begin
            for (int pa = 0; pa < 4; pa++) begin
                for (int s = 0; s < 4; s++) begin
                    int na, nb, pb, p, er, ef;
                    logic [15:0] selw;
                    na = (ia == 0) ? 0 : (ia == 1) ? 1 : (ia == 2) ? 2 : (ia == 3) ? 5 : 63;
                    nb = (na * 5 + 3) % 64;
                    pb = 3 - pa;
                    p  = (ia * 16 + pa * 4 + s) % NP;
                    selw = '0;
                    for (int q = 0; q < NP; q++) begin
                        selw[2*q]   = s[0];
                        selw[2*q+1] = s[1];
                    end
                    wr(1'b0, tim_word(na, pa, nb, pb));
                    wr(1'b1, selw);
                    er = s[0] ? (nb << pb) : (na << pa);
                    ef = s[1] ? (nb << pb) : (na << pa);
                    repeat ((ia + pa + s) % 7) @(negedge clk);
                    measure(p, 1'b1, er, (er == 0) ? "R6" : (s[0] ? "R4" : "R2"));
                    repeat ((ia + s) % 3) @(negedge clk);
                    measure(p, 1'b0, ef, (ef == 0) ? "R6" : (s[1] ? "R4" : "R3"));
                    if (pa == 3) chk(1'b1 && er == (s[0] ? nb*8 >> (3-pb) : na*8), "R5", er, er);
                end
            end
        end

        // R8 reversal during a gap: rise uses A=10, fall uses B=4
        wr(1'b0, tim_word(10, 0, 4, 0));
        wr(1'b1, 16'h0020);
        duty_in[2] = 1'b1;
        repeat (3) @(negedge clk);
        chk(!out_hi[2] && !out_lo[2], "R8", out_hi[2], 0);
        measure(2, 1'b0, 4, "R8");
        chk(!out_hi[2], "R8", out_hi[2], 0);
        repeat (12) @(negedge clk);
        chk(!out_hi[2] && out_lo[2], "R8", out_hi[2], 0);

        // R9 independent mode on pair 1 (mode bit 2*NP+1)
        wr(1'b1, 16'h0200);
        for (int i = 0; i < 8; i++) begin
            logic v;
            v = i[0] ^ i[2];
            duty_in[1] = v;
            @(negedge clk);
            chk(out_hi[1] == v && out_lo[1] == !v, "R9", {out_hi[1], out_lo[1]}, {v, !v});
        end
        duty_in[1] = 1'b0;
        @(negedge clk);
        wr(1'b1, 16'h0000);

        // R10 writes while running are ignored
        run_en = 1'b1;
        wr(1'b0, tim_word(0, 0, 0, 0));
        wr(1'b1, 16'h0F00);
        run_en = 1'b0;
        measure(0, 1'b1, 10, "R10");
        measure(0, 1'b0, 10, "R10");

        chk(both_on == 0, "R7", both_on, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule